// File: doc/BRIEF.md
# Three-Phase Bridge Fault Supervisor

This block collects the digitized protection flags of a three-phase power stage and turns them into two active-low status outputs and one high-impedance enable per half-bridge. The flags are per-phase overcurrent, overtemperature warning, overtemperature shutdown and gate-supply undervoltage. All of them come from another clock domain and pass through a two-flop synchronizer before use.

A shutdown-class fault (overcurrent, overtemperature shutdown, undervoltage) puts every half-bridge into high impedance in the same cycle that the synchronized flag appears. One cycle later the registered fault output goes low. An undervoltage fault clears by itself once the supply flag goes away. Overcurrent and overtemperature shutdowns are held in a latch. The latch is released only by a clear request that arrives once the minimum hold time has elapsed since the shutdown. That hold time is `CLK_HZ * HOLD_SEC` clock cycles. A clear request that comes too early is dropped and is not remembered. The warning output follows the temperature-warning flag and never forces high impedance.

Top module: `bfs_top`

## Requirements
- R1: While `rst` is high, every bit of `hiz` is 1. In the first cycle after `rst` is released with no flags present, `fault_n` = 1, `warn_n` = 1 and `hiz` = 0.
- R2: `warn_n` goes low three clock edges after a raw `ot_warn` rises (two synchronizer edges plus the output register) and follows the flag back high. The warning alone leaves `fault_n` high and `hiz` = 0.
- R3: Any raw shutdown flag (`uv_raw`, `ot_shut`, or any bit of `oc_raw`) makes all `hiz` bits 1 after two clock edges. `fault_n` goes low one edge later.
- R4: The pair {`fault_n`,`warn_n`} encodes the state: 2'b00 means warning plus shutdown fault, 2'b01 means shutdown fault without warning, 2'b10 means warning only, and 2'b11 means normal.
- R5: Undervoltage recovers by itself. When `uv_raw` falls with no other flag present, `hiz` returns to 0 after two edges and `fault_n` returns to 1 after three.
- R6: An overcurrent or overtemperature shutdown stays latched after its raw flag falls. `fault_n` stays low and `hiz` stays all ones until a clear request is accepted.
- R7: `clr_req` is accepted only at an edge where at least `CLK_HZ*HOLD_SEC` cycles have elapsed since the latch was set. An earlier pulse is discarded and has no effect later. On acceptance, `fault_n` is 1 and `hiz` is 0 right after that edge.
- R8: A clear that is accepted while a latched flag is still present leaves the latch set and restarts the hold count from zero.
- R9: `clr_req` has no effect on an undervoltage fault or on a fault-free block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_raw | input | PHASES | Per-phase overcurrent flags, asynchronous |
| ot_warn | input | 1 | Overtemperature warning flag, asynchronous |
| ot_shut | input | 1 | Overtemperature shutdown flag, asynchronous |
| uv_raw | input | 1 | Gate-supply undervoltage flag, asynchronous |
| clr_req | input | 1 | External request to clear a latched shutdown |
| fault_n | output | 1 | Active-low shutdown-fault status, registered |
| warn_n | output | 1 | Active-low temperature-warning status, registered |
| hiz | output | PHASES | Per-phase high-impedance enable |

## Verification
On every cycle, the assertions check the following: bridges are high impedance whenever the latch is set or reset is active; a synchronized shutdown or warning flag is reflected on the status pins one edge later; an early clear never releases the latch; and the hold count stays in range and restarts on a clear that re-latches. Only the bench scenarios can show the end-to-end latency from the raw flags, the exact hold boundary, that an early pulse is not remembered, that undervoltage recovers by itself, and the full four-code status encoding.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    // synchronized protection flags, overcurrent already reduced over phases
    typedef struct packed {
        logic uv;
        logic ots;
        logic otw;
        logic oc;
    } flags_t;

    function automatic int hold_cycles(input int hz, input int sec);
        return hz * sec;
    endfunction

    function automatic int cnt_width(input int top);
        return (top < 2) ? 1 : $clog2(top + 1);
    endfunction

    // status pins are active low
    function automatic logic [1:0] pin_pair(input logic shut, input logic warn);
        return {~shut, ~warn};
    endfunction

endpackage

// File: rtl/bfs_sync.sv
module bfs_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/bfs_latch.sv
module bfs_latch #(
    parameter int HOLD_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic set_in,
    input  logic clr_req,
    output logic latched_q,
    output logic latched_d
);
    localparam int CW = bfs_pkg::cnt_width(HOLD_CYC);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

    logic [CW-1:0] cnt;
    logic          hold_done;
    logic          accept;

    assign hold_done = (cnt == HOLD_V);
    assign accept    = latched_q & clr_req & hold_done;
    assign latched_d = (latched_q & ~accept) | set_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched_q <= 1'b0;
            cnt       <= '0;
        end else begin
            latched_q <= latched_d;
            if (!latched_q || accept)
                cnt <= '0;
            else if (!hold_done)
                cnt <= cnt + 1'b1;
        end
    end

    // R7: an early clear never releases the latch
    a_r7_early_clear_kept: assert property (@(posedge clk) disable iff (rst)
        (latched_q && !hold_done && clr_req) |=> latched_q);

    // R6: without a clear, the latch holds
    a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (latched_q && !clr_req) |=> latched_q);

    // R7: hold count never passes its limit
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= HOLD_V);

    // R8: accepted clear with flag still present re-latches and restarts
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        (latched_q && clr_req && hold_done && set_in) |=> (latched_q && cnt == '0));
endmodule

// File: rtl/bfs_status.sv
module bfs_status (
    input  logic clk,
    input  logic rst,
    input  logic shut_d,
    input  logic warn_d,
    output logic fault_n,
    output logic warn_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fault_n <= 1'b1;
            warn_n  <= 1'b1;
        end else begin
            {fault_n, warn_n} <= bfs_pkg::pin_pair(shut_d, warn_d);
        end
    end

    // R3: a shutdown condition shows on fault_n at the next edge
    a_r3_fault_follows: assert property (@(posedge clk) disable iff (rst)
        shut_d |=> !fault_n);

    // R2: the warning shows on warn_n at the next edge
    a_r2_warn_follows: assert property (@(posedge clk) disable iff (rst)
        warn_d |=> !warn_n);

    // R5: no condition means fault_n returns high
    a_r5_clear_follows: assert property (@(posedge clk) disable iff (rst)
        !shut_d |=> fault_n);
endmodule

// File: rtl/bfs_top.sv
module bfs_top #(
    parameter int PHASES   = 3,
    parameter int CLK_HZ   = 100_000_000,
    parameter int HOLD_SEC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHASES-1:0] oc_raw,
    input  logic              ot_warn,
    input  logic              ot_shut,
    input  logic              uv_raw,
    input  logic              clr_req,
    output logic              fault_n,
    output logic              warn_n,
    output logic [PHASES-1:0] hiz
);
    import bfs_pkg::*;

    localparam int HOLD_CYC = hold_cycles(CLK_HZ, HOLD_SEC);
    localparam int SW       = PHASES + 3;

    logic [SW-1:0] raw_vec;
    logic [SW-1:0] syn_vec;
    flags_t        fl;
    logic          latched_q;
    logic          latched_d;
    logic          force_hiz;

    assign raw_vec = {uv_raw, ot_shut, ot_warn, oc_raw};

    bfs_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_vec),
        .q   (syn_vec)
    );

    assign fl.uv  = syn_vec[SW-1];
    assign fl.ots = syn_vec[SW-2];
    assign fl.otw = syn_vec[SW-3];
    assign fl.oc  = |syn_vec[PHASES-1:0];

    bfs_latch #(.HOLD_CYC(HOLD_CYC)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .set_in    (fl.oc | fl.ots),
        .clr_req   (clr_req),
        .latched_q (latched_q),
        .latched_d (latched_d)
    );

    bfs_status u_status (
        .clk     (clk),
        .rst     (rst),
        .shut_d  (latched_d | fl.uv),
        .warn_d  (fl.otw),
        .fault_n (fault_n),
        .warn_n  (warn_n)
    );

    assign force_hiz = rst | latched_q | fl.uv | fl.oc | fl.ots;

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        assign hiz[p] = force_hiz;
    end

    // R1: bridges are off while in reset
    always_ff @(posedge clk) begin
        if (rst) begin
            a_r1_hiz_in_reset: assert (&hiz);
        end
    end

    // R6: a latched shutdown keeps every bridge off
    a_r6_latched_hiz: assert property (@(posedge clk) disable iff (rst)
        latched_q |-> &hiz);

    // R3: a synchronized shutdown flag turns the bridges off at once
    a_r3_flag_hiz: assert property (@(posedge clk) disable iff (rst)
        (fl.uv || fl.oc || fl.ots) |-> &hiz);
endmodule

// File: tb/bfs_top_test.sv
module bfs_top_test;
    localparam int PH   = 3;
    localparam int HZ   = 40;
    localparam int HOLD = HZ * 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PH-1:0] oc_raw = '0;
    logic          ot_warn = 1'b0;
    logic          ot_shut = 1'b0;
    logic          uv_raw = 1'b0;
    logic          clr_req = 1'b0;
    logic          fault_n;
    logic          warn_n;
    logic [PH-1:0] hiz;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bfs_top #(.PHASES(PH), .CLK_HZ(HZ), .HOLD_SEC(1)) uut (
        .clk(clk), .rst(rst), .oc_raw(oc_raw), .ot_warn(ot_warn),
        .ot_shut(ot_shut), .uv_raw(uv_raw), .clr_req(clr_req),
        .fault_n(fault_n), .warn_n(warn_n), .hiz(hiz)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_clear();
        clr_req = 1'b1;
        step(1);
        clr_req = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(2);
        check("R1 hiz in reset", hiz, 7);
        rst = 1'b0;
        step(1);
        check("R1 pins after reset", {fault_n, warn_n}, 3);
        check("R1 hiz after reset", hiz, 0);
    endtask

    task automatic t_warn();
        ot_warn = 1'b1;
        step(2);
        check("R2 warn not yet", warn_n, 1);
        step(1);
        check("R2 warn low", warn_n, 0);
        check("R4 code warning only", {fault_n, warn_n}, 2);
        check("R2 no hiz on warning", hiz, 0);
        ot_warn = 1'b0;
        step(3);
        check("R4 code normal", {fault_n, warn_n}, 3);
    endtask

    task automatic t_uv();
        uv_raw = 1'b1;
        step(2);
        check("R3 hiz after two edges", hiz, 7);
        check("R3 fault not yet", fault_n, 1);
        step(1);
        check("R4 code shutdown only", {fault_n, warn_n}, 1);
        pulse_clear();
        check("R9 clear ignored on uv", fault_n, 0);
        uv_raw = 1'b0;
        step(2);
        check("R5 hiz released", hiz, 0);
        step(1);
        check("R5 fault released", fault_n, 1);
        pulse_clear();
        check("R9 clear on idle", {fault_n, warn_n, hiz}, 24);
    endtask

    task automatic t_combo();
        ot_warn = 1'b1;
        oc_raw  = 3'b010;
        step(3);
        check("R4 code both", {fault_n, warn_n}, 0);
        check("R3 hiz on phase oc", hiz, 7);
        ot_warn = 1'b0;
        oc_raw  = '0;
        step(3);
        check("R6 code latched", {fault_n, warn_n}, 1);
        step(HOLD);
        pulse_clear();
        check("R7 combo cleared", {fault_n, warn_n}, 3);
    endtask

    task automatic t_latch_oc();
        oc_raw = 3'b100;
        step(3);
        oc_raw = '0;
        step(5);
        check("R6 fault held", fault_n, 0);
        check("R6 hiz held", hiz, 7);
        step(10);
        pulse_clear();
        check("R7 early clear ignored", fault_n, 0);
        step(HOLD);
        check("R7 early clear not queued", fault_n, 0);
        pulse_clear();
        check("R7 late clear fault", fault_n, 1);
        check("R7 late clear hiz", hiz, 0);
    endtask

    task automatic t_boundary();
        ot_shut = 1'b1;
        step(3);
        ot_shut = 1'b0;
        step(HOLD - 1);
        pulse_clear();
        check("R7 one cycle short", fault_n, 0);
        pulse_clear();
        check("R7 exact hold accepted", fault_n, 1);
    endtask

    task automatic t_restart();
        ot_shut = 1'b1;
        step(3 + HOLD);
        pulse_clear();
        check("R8 relatched fault", fault_n, 0);
        check("R8 relatched hiz", hiz, 7);
        ot_shut = 1'b0;
        step(HOLD - 2);
        pulse_clear();
        check("R8 count restarted", fault_n, 0);
        step(5);
        pulse_clear();
        check("R8 clear after restart", fault_n, 1);
    endtask

    initial begin
        step(1);
        t_reset();
        t_warn();
        t_uv();
        t_combo();
        t_latch_oc();
        t_boundary();
        t_restart();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule